// File: doc/BRIEF.md
# Link Layer Frame Transmit Sequencer

This block drives the transmit side of a serial storage link layer for one frame at a time. The frame payload sits in a dword FIFO in front of the block and already carries its CRC and scrambling. The block starts a frame with a ready handshake. It then brackets the payload with start and end delimiters and pauses whenever the far end asks for flow control. Finally it waits until the far end reports the receive status. While it has no frame to send, it emits the idle primitive.

Primitives are 32-bit dwords marked by a control flag. Each received dword is decoded into a small set of flags: ready-to-receive, hold, good status and bad status. The sequencer steps through idle, ready, start, data, end and wait states. An output multiplexer chooses the transmitted dword from the current state. At completion the block emits a one-cycle done pulse, together with an error pulse when the status was bad.

Top module: `ltx_link_tx_seq`

## Requirements
- R1: While rst_ni is low, the block sends SYNC (0xB5B5957C) with tx_k_o=1, and fifo_pop_o, done_o and err_o are 0.
- R2: In idle, SYNC is sent while fifo_empty_i is 1. At the first clock edge where fifo_empty_i is 0, the block leaves idle, and X_RDY is sent from the next cycle on.
- R3: X_RDY (0x5757B57C, tx_k_o=1) repeats every cycle until R_RDY (0x4A4A957C) is received. After the edge that samples R_RDY, SOF (0x3737B57C) is sent for exactly one cycle.
- R4: In data, every cycle without a received HOLD sends fifo_data_i with tx_k_o=0 and asserts fifo_pop_o.
- R5: In data, a received HOLD (0xD5D5AA7C) sends HOLDA (0x9595AA7C, tx_k_o=1) with fifo_pop_o=0, and the payload does not advance.
- R6: After the dword popped with fifo_last_i=1, EOF (0xD5D5B57C) is sent for one cycle, followed by WTRM (0x5858B57C) on every cycle until a status arrives.
- R7: R_OK (0x3535B57C) received during WTRM ends the frame. On the next cycle done_o=1, err_o=0 and SYNC is sent. done_o lasts one cycle.
- R8: R_ERR (0x5656B57C) received during WTRM ends the frame with done_o=1 and err_o=1 on the next cycle, for one cycle.
- R9: A received dword counts as a primitive only when rx_k_i=1. A dword equal to R_RDY with rx_k_i=0 leaves the block sending X_RDY.
- R10: A primitive that does not belong to the current state has no effect. HOLD during ready keeps X_RDY, and R_OK during data still sends the payload dword and pops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_data_i | input | 32 | Head dword of the payload FIFO (first-word fall-through) |
| fifo_last_i | input | 1 | Head dword is the final dword of the frame |
| fifo_empty_i | input | 1 | Payload FIFO holds no dword |
| fifo_pop_o | output | 1 | Consume the head dword at this edge |
| rx_dword_i | input | 32 | Dword received from the far end |
| rx_k_i | input | 1 | Received dword is a control primitive |
| tx_dword_o | output | 32 | Dword to transmit |
| tx_k_o | output | 1 | Transmitted dword is a control primitive |
| done_o | output | 1 | One-cycle pulse when a frame has completed |
| err_o | output | 1 | One-cycle pulse with done_o when the status was R_ERR |

## Verification
The assertions assume that the payload FIFO is never empty while the sequencer wants to send a payload dword. In other words, a frame is present in the FIFO in full, up to its last-flagged dword, before the sequencer leaves idle. The bench loads each frame into its FIFO model in a single step while the block is idle, and it raises the last flag on the final dword. The far-end model changes rx_dword_i and rx_k_i once per cycle, away from the clock edge, so each received primitive is sampled at exactly one edge.

// File: rtl/ltx_pkg.sv
package ltx_pkg;
  localparam int unsigned DW = 32;

  localparam logic [DW-1:0] P_SYNC  = 32'hB5B5_957C;
  localparam logic [DW-1:0] P_X_RDY = 32'h5757_B57C;
  localparam logic [DW-1:0] P_R_RDY = 32'h4A4A_957C;
  localparam logic [DW-1:0] P_SOF   = 32'h3737_B57C;
  localparam logic [DW-1:0] P_EOF   = 32'hD5D5_B57C;
  localparam logic [DW-1:0] P_WTRM  = 32'h5858_B57C;
  localparam logic [DW-1:0] P_HOLD  = 32'hD5D5_AA7C;
  localparam logic [DW-1:0] P_HOLDA = 32'h9595_AA7C;
  localparam logic [DW-1:0] P_R_OK  = 32'h3535_B57C;
  localparam logic [DW-1:0] P_R_ERR = 32'h5656_B57C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDY,
    ST_SOF,
    ST_DATA,
    ST_EOF,
    ST_WTRM
  } ltx_state_e;

  typedef struct packed {
    logic r_rdy;
    logic hold;
    logic r_ok;
    logic r_err;
  } ltx_rx_prim_t;
endpackage

// File: rtl/ltx_prim_decode.sv
module ltx_prim_decode
  import ltx_pkg::*;
#(
  parameter bit REQUIRE_K = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rx_dword_i,
  input  logic          rx_k_i,
  output ltx_rx_prim_t  prim_o
);
  logic k_ok;

  generate
    if (REQUIRE_K) begin : g_k_gate
      assign k_ok = rx_k_i;
    end else begin : g_no_k_gate
      logic unused_k;
      assign unused_k = rx_k_i;
      assign k_ok     = 1'b1;
    end
  endgenerate

  always_comb begin
    prim_o       = '0;
    prim_o.r_rdy = k_ok && (rx_dword_i == P_R_RDY);
    prim_o.hold  = k_ok && (rx_dword_i == P_HOLD);
    prim_o.r_ok  = k_ok && (rx_dword_i == P_R_OK);
    prim_o.r_err = k_ok && (rx_dword_i == P_R_ERR);
  end

  // R9
  prim_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(prim_o));

  // R9
  prim_needs_k_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (REQUIRE_K && !rx_k_i) |-> (prim_o == '0));
endmodule

// File: rtl/ltx_seq_fsm.sv
module ltx_seq_fsm
  import ltx_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fifo_empty_i,
  input  logic         fifo_last_i,
  input  ltx_rx_prim_t prim_i,
  output ltx_state_e   state_o,
  output logic         fifo_pop_o,
  output logic         done_o,
  output logic         err_o
);
  ltx_state_e state_q, state_d;
  logic       done_d, err_d;

  always_comb begin
    state_d    = state_q;
    fifo_pop_o = 1'b0;
    done_d     = 1'b0;
    err_d      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (!fifo_empty_i) state_d = ST_RDY;
      ST_RDY:  if (prim_i.r_rdy) state_d = ST_SOF;
      ST_SOF:  state_d = ST_DATA;
      ST_DATA: begin
        if (!prim_i.hold) begin
          fifo_pop_o = 1'b1;
          if (fifo_last_i) state_d = ST_EOF;
        end
      end
      ST_EOF:  state_d = ST_WTRM;
      ST_WTRM: begin
        if (prim_i.r_ok || prim_i.r_err) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = prim_i.r_err;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      err_o   <= err_d;
    end
  end

  assign state_o = state_q;

  // R5
  hold_no_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_i.hold |-> !fifo_pop_o);

  // R4
  fifo_not_dry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);

  // R6
  last_pop_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_pop_o && fifo_last_i) |=> (state_q == ST_EOF));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_from_wtrm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(state_q) == ST_WTRM));

  // R8
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R3
  sof_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOF) |=> (state_q == ST_DATA));
endmodule

// File: rtl/ltx_tx_mux.sv
module ltx_tx_mux
  import ltx_pkg::*;
(
  input  ltx_state_e    state_i,
  input  logic          hold_i,
  input  logic [DW-1:0] fifo_data_i,
  output logic [DW-1:0] tx_dword_o,
  output logic          tx_k_o
);
  always_comb begin
    tx_k_o = 1'b1;
    unique case (state_i)
      ST_IDLE: tx_dword_o = P_SYNC;
      ST_RDY:  tx_dword_o = P_X_RDY;
      ST_SOF:  tx_dword_o = P_SOF;
      ST_DATA: begin
        if (hold_i) begin
          tx_dword_o = P_HOLDA;
        end else begin
          tx_dword_o = fifo_data_i;
          tx_k_o     = 1'b0;
        end
      end
      ST_EOF:  tx_dword_o = P_EOF;
      ST_WTRM: tx_dword_o = P_WTRM;
      default: tx_dword_o = P_SYNC;
    endcase
  end
endmodule

// File: rtl/ltx_link_tx_seq.sv
module ltx_link_tx_seq
  import ltx_pkg::*;
#(
  parameter bit REQUIRE_K = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] fifo_data_i,
  input  logic          fifo_last_i,
  input  logic          fifo_empty_i,
  output logic          fifo_pop_o,
  input  logic [DW-1:0] rx_dword_i,
  input  logic          rx_k_i,
  output logic [DW-1:0] tx_dword_o,
  output logic          tx_k_o,
  output logic          done_o,
  output logic          err_o
);
  ltx_rx_prim_t prim;
  ltx_state_e   state;

  ltx_prim_decode #(.REQUIRE_K(REQUIRE_K)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_dword_i (rx_dword_i),
    .rx_k_i     (rx_k_i),
    .prim_o     (prim)
  );

  ltx_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fifo_empty_i (fifo_empty_i),
    .fifo_last_i  (fifo_last_i),
    .prim_i       (prim),
    .state_o      (state),
    .fifo_pop_o   (fifo_pop_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  ltx_tx_mux u_mux (
    .state_i     (state),
    .hold_i      (prim.hold),
    .fifo_data_i (fifo_data_i),
    .tx_dword_o  (tx_dword_o),
    .tx_k_o      (tx_k_o)
  );

  // R4
  payload_pops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_k_o |-> fifo_pop_o);

  // R7
  done_sends_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tx_dword_o == P_SYNC && tx_k_o));

  // R6
  eof_to_wtrm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_dword_o == P_EOF && tx_k_o) |=> (tx_dword_o == P_WTRM && tx_k_o));
endmodule

// File: tb/ltx_link_tx_seq_tb_top.sv
module ltx_link_tx_seq_tb_top;
  import ltx_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] rx_dword = P_SYNC;
  logic        rx_k = 1'b1;
  logic [31:0] tx_dword;
  logic        tx_k, pop, done, err;

  logic [31:0] fmem [32];
  int          fcount = 0;
  int          fidx = 0;
  logic [31:0] fifo_data;
  logic        fifo_last, fifo_empty;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  assign fifo_data  = fmem[fidx[4:0]];
  assign fifo_empty = (fidx >= fcount);
  assign fifo_last  = (fidx == fcount - 1);

  always @(posedge clk) if (pop) fidx <= fidx + 1;

  ltx_link_tx_seq dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .fifo_data_i  (fifo_data),
    .fifo_last_i  (fifo_last),
    .fifo_empty_i (fifo_empty),
    .fifo_pop_o   (pop),
    .rx_dword_i   (rx_dword),
    .rx_k_i       (rx_k),
    .tx_dword_o   (tx_dword),
    .tx_k_o       (tx_k),
    .done_o       (done),
    .err_o        (err)
  );

  task automatic expect_out(string req, logic [31:0] dw, logic k, logic p, logic d, logic e);
    logic [35:0] act, exp;
    act = {tx_dword, tx_k, pop, done, err};
    exp = {dw, k, p, d, e};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {tx,k,pop,done,err} actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [31:0] dw, logic k);
    @(negedge clk);
    rx_dword = dw;
    rx_k     = k;
    #1;
  endtask

  task automatic t_reset();
    #1;
    expect_out("R1", P_SYNC, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      cyc(P_SYNC, 1'b1);
      expect_out("R2", P_SYNC, 1'b1, 1'b0, 1'b0, 1'b0);
    end
  endtask

  // n words, hold before word i when hold_mask[i]; bad selects R_ERR; inject R_OK in data when stray
  task automatic t_frame(int n, logic [7:0] hold_mask, logic [31:0] seed, logic bad, logic stray);
    for (int i = 0; i < n; i++) fmem[fcount + i] = seed + 32'h0101_0101 * i;
    fcount = fcount + n;
    // ready: background, R_RDY without k (R9), HOLD (R10)
    cyc(P_SYNC, 1'b1);
    expect_out("R2", P_X_RDY, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(P_R_RDY, 1'b0);
    expect_out("R9", P_X_RDY, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(P_HOLD, 1'b1);
    expect_out("R10", P_X_RDY, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(P_R_RDY, 1'b1);
    expect_out("R3", P_X_RDY, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(P_SYNC, 1'b1);
    expect_out("R3", P_SOF, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = seed + 32'h0101_0101 * i;
      if (hold_mask[i]) begin
        cyc(P_HOLD, 1'b1);
        expect_out("R5", P_HOLDA, 1'b1, 1'b0, 1'b0, 1'b0);
      end
      if (stray && i == 1) begin
        cyc(P_R_OK, 1'b1);
        expect_out("R10", w, 1'b0, 1'b1, 1'b0, 1'b0);
      end else begin
        cyc(32'h0BAD_F00D, 1'b0);
        expect_out("R4", w, 1'b0, 1'b1, 1'b0, 1'b0);
      end
    end
    cyc(P_SYNC, 1'b1);
    expect_out("R6", P_EOF, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(P_SYNC, 1'b1);
    expect_out("R6", P_WTRM, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(P_HOLD, 1'b1);
    expect_out("R6", P_WTRM, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(bad ? P_R_ERR : P_R_OK, 1'b1);
    expect_out("R6", P_WTRM, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(P_SYNC, 1'b1);
    expect_out(bad ? "R8" : "R7", P_SYNC, 1'b1, 1'b0, 1'b1, bad);
    cyc(P_SYNC, 1'b1);
    expect_out(bad ? "R8" : "R7", P_SYNC, 1'b1, 1'b0, 1'b0, 1'b0);
    checks++;
    if (fidx != fcount) begin
      failures++;
      $display("FAIL R4: fifo index actual=%0d expected=%0d", fidx, fcount);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_frame(4, 8'b0000_0101, 32'h1000_0000, 1'b0, 1'b1);
    t_frame(3, 8'b0000_0100, 32'h2000_0000, 1'b1, 1'b0);
    t_frame(1, 8'b0000_0000, 32'h3000_0000, 1'b0, 1'b0);
    finish_run();
  end
endmodule